// File: doc/BRIEF.md
# String Operation Repeat Sequencer

This block steps a string instruction through memory and I/O one element at a time. It covers seven operations: move, compare, store, load, scan, port input and port output. A start pulse captures several values together: the operation, the element size, the address width, the direction, the repeat kind, the instruction length and the initial source index, destination index, count and program counter. The block then issues one or two requests per element on a single valid/ready request channel. After every handshake of an element has completed, it moves the index registers that the operation uses.

With a repeat kind selected, the count is tested before each element and decremented after it. Compare and scan can also end early, depending on the zero flag that the external datapath returns for each element. With 16-bit addressing, every index and count update wraps inside the low 16 bits and leaves the upper bits untouched. When the sequence ends, a one-cycle done pulse appears and the program counter output has advanced by the instruction length.

Top module: `str_seq_top`

## Requirements
- R1: After reset, busy_o, done_o and req_valid_o are all 0.
- R2: Operation codes and their requests per element. Move (0) reads memory at the source, then writes memory at the destination. Compare (1) reads memory at the source, then reads memory at the destination. Store (2) writes memory at the destination. Load (3) reads memory at the source. Scan (4) reads memory at the destination. Port input (5) reads the port, then writes memory at the destination. Port output (6) reads memory at the source, then writes the port. For a port request, req_port_o is 1 and req_addr_o is the port number zero-extended. req_write_o is 1 for a write. req_bytes_o is 1, 2 or 4 for size codes 0, 1 and 2.
- R3: After each element, each index the operation uses changes by the element size. It decreases when dir_dn_i is 1 and increases when dir_dn_i is 0. Move and compare use both indexes. Store, scan and port input use only the destination. Load and port output use only the source.
- R4: With addr32_i = 0, index and count updates wrap within bits 15:0 and keep bits 31:16. Memory request addresses carry only bits 15:0, zero-extended. The count is compared with zero over bits 15:0 only.
- R5: Under a repeat kind (rep_i != 0), the count is tested before every element. A starting count of zero issues no request, leaves all registers unchanged and still produces done.
- R6: Under a repeat kind, the count is decremented by one after each element, and the sequence ends when the count reaches zero.
- R7: For compare and scan only: with rep_i = 1 (while equal), the sequence stops after an element whose zero flag is 0. With rep_i = 2 (while not equal), it stops after an element whose zero flag is 1. rep_i = 3 and all other operations repeat on the count alone, whatever the zero flag. The zero flag is zf_i, sampled two cycles after the element's last handshake.
- R8: With rep_i = 0, exactly one element is performed whatever the count, and cnt_o is unchanged.
- R9: At the end of a sequence, done_o is high for exactly one cycle, busy_o is low in that cycle, and pc_o equals pc_i plus len_i.
- R10: A request whose req_ready_i is low holds its valid, address and kind unchanged, and no index or count moves while it is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a sequence (taken when idle) |
| op_i | input | 3 | Operation code (see R2) |
| esize_i | input | 2 | Element size code: 0=1, 1=2, 2=4 bytes |
| addr32_i | input | 1 | 1 = 32-bit addressing, 0 = 16-bit |
| dir_dn_i | input | 1 | 1 = indexes decrease |
| rep_i | input | 2 | 0 none, 1 while equal, 2 while not equal, 3 count only |
| len_i | input | LEN_W | Instruction length added to the program counter |
| pc_i | input | AW | Initial program counter |
| src_i | input | AW | Initial source index |
| dst_i | input | AW | Initial destination index |
| cnt_i | input | AW | Initial count |
| port_i | input | PORT_W | Port number for port operations |
| zf_i | input | 1 | Zero flag of the last element |
| req_valid_o | output | 1 | Request valid |
| req_ready_i | input | 1 | Request accepted |
| req_write_o | output | 1 | 1 = write, 0 = read |
| req_port_o | output | 1 | 1 = port space, 0 = memory |
| req_addr_o | output | AW | Request address |
| req_bytes_o | output | 3 | Bytes in the request |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |
| src_o | output | AW | Current source index |
| dst_o | output | AW | Current destination index |
| cnt_o | output | AW | Current count |
| pc_o | output | AW | Program counter |

## Verification
Each operation code is run at least once, so that the order, direction and address source of its requests are told apart. Requests are accepted under a repeating stall pattern, which shows whether requests hold steady and whether index updates wait for the handshake. Zero-flag patterns that stop a compare or scan part-way are set beside identical patterns on a move and on a count-only repeat, which separates early termination from count exhaustion. Runs with 16-bit addressing start next to the wrap point in both directions. A zero starting count is run with and without a repeat kind, which separates the count test from the single-element path.

// File: rtl/str_seq_pkg.sv
package str_seq_pkg;

  typedef enum logic [2:0] {
    OP_MOVE  = 3'd0,
    OP_CMP   = 3'd1,
    OP_STORE = 3'd2,
    OP_LOAD  = 3'd3,
    OP_SCAN  = 3'd4,
    OP_PIN   = 3'd5,
    OP_POUT  = 3'd6,
    OP_RSVD  = 3'd7
  } str_op_e;

  typedef enum logic [1:0] {
    REP_NONE  = 2'd0,
    REP_EQ    = 2'd1,
    REP_NE    = 2'd2,
    REP_COUNT = 2'd3
  } rep_e;

  typedef enum logic [2:0] {
    S_IDLE = 3'd0,
    S_TEST = 3'd1,
    S_PH0  = 3'd2,
    S_PH1  = 3'd3,
    S_UPD  = 3'd4,
    S_CHK  = 3'd5
  } seq_st_e;

  typedef struct packed {
    logic wr;
    logic port;
    logic use_dst;
  } phase_t;

  typedef struct packed {
    logic   two;
    phase_t p0;
    phase_t p1;
    logic   src_mv;
    logic   dst_mv;
    logic   zf_term;
  } op_dec_t;

  function automatic op_dec_t decode_op(str_op_e op);
    op_dec_t d;
    d = '0;
    unique case (op)
      OP_MOVE:  begin d.two = 1'b1; d.p1 = '{1'b1, 1'b0, 1'b1};
                      d.src_mv = 1'b1; d.dst_mv = 1'b1; end
      OP_CMP:   begin d.two = 1'b1; d.p1 = '{1'b0, 1'b0, 1'b1};
                      d.src_mv = 1'b1; d.dst_mv = 1'b1; d.zf_term = 1'b1; end
      OP_STORE: begin d.p0 = '{1'b1, 1'b0, 1'b1}; d.dst_mv = 1'b1; end
      OP_SCAN:  begin d.p0 = '{1'b0, 1'b0, 1'b1}; d.dst_mv = 1'b1; d.zf_term = 1'b1; end
      OP_PIN:   begin d.two = 1'b1; d.p0 = '{1'b0, 1'b1, 1'b0};
                      d.p1 = '{1'b1, 1'b0, 1'b1}; d.dst_mv = 1'b1; end
      OP_POUT:  begin d.two = 1'b1; d.p1 = '{1'b1, 1'b1, 1'b0}; d.src_mv = 1'b1; end
      default:  begin d.src_mv = 1'b1; end
    endcase
    return d;
  endfunction

endpackage

// File: rtl/str_idx_step.sv
module str_idx_step #(
  parameter int AW = 32,
  parameter int NW = 16
) (
  input  logic [AW-1:0] val_i,
  input  logic [2:0]    step_i,
  input  logic          dn_i,
  input  logic          wide_i,
  output logic [AW-1:0] nxt_o
);
  logic [AW-1:0] step_w, full_w;
  logic [NW-1:0] step_n, nar_w;

  always_comb begin
    step_w = {{(AW-3){1'b0}}, step_i};
    step_n = {{(NW-3){1'b0}}, step_i};
    full_w = dn_i ? (val_i - step_w) : (val_i + step_w);
    nar_w  = dn_i ? (val_i[NW-1:0] - step_n) : (val_i[NW-1:0] + step_n);
    nxt_o  = wide_i ? full_w : {val_i[AW-1:NW], nar_w};
  end
endmodule

// File: rtl/str_seq_fsm.sv
module str_seq_fsm
  import str_seq_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    start_i,
  input  rep_e    rep_i,
  input  logic    zf_term_i,
  input  logic    two_i,
  input  logic    cnt_zero_i,
  input  logic    ready_i,
  input  logic    zf_i,
  output seq_st_e st_o,
  output logic    load_o,
  output logic    upd_o,
  output logic    fin_o
);
  seq_st_e st_q, st_d;
  logic    zf_stop;

  always_comb begin
    zf_stop = zf_term_i && (((rep_i == REP_EQ) && !zf_i) || ((rep_i == REP_NE) && zf_i));
    st_d    = st_q;
    fin_o   = 1'b0;
    unique case (st_q)
      S_IDLE: if (start_i) st_d = S_TEST;
      S_TEST: begin
        if ((rep_i != REP_NONE) && cnt_zero_i) begin
          st_d  = S_IDLE;
          fin_o = 1'b1;
        end else begin
          st_d = S_PH0;
        end
      end
      S_PH0: if (ready_i) st_d = two_i ? S_PH1 : S_UPD;
      S_PH1: if (ready_i) st_d = S_UPD;
      S_UPD: st_d = S_CHK;
      S_CHK: begin
        if ((rep_i == REP_NONE) || zf_stop) begin
          st_d  = S_IDLE;
          fin_o = 1'b1;
        end else begin
          st_d = S_TEST;
        end
      end
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= S_IDLE;
    else        st_q <= st_d;
  end

  assign st_o   = st_q;
  assign load_o = (st_q == S_IDLE) && start_i;
  assign upd_o  = (st_q == S_UPD);

  AST_SECOND_PHASE_ONLY_TWO: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_PH1) |-> two_i); // R2
  AST_ZERO_COUNT_NO_ELEMENT: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == S_TEST) && (rep_i != REP_NONE) && cnt_zero_i) |=> (st_q == S_IDLE)); // R5
endmodule

// File: rtl/str_seq_top.sv
module str_seq_top
  import str_seq_pkg::*;
#(
  parameter int AW     = 32,
  parameter int NW     = 16,
  parameter int PORT_W = 16,
  parameter int LEN_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [2:0]        op_i,
  input  logic [1:0]        esize_i,
  input  logic              addr32_i,
  input  logic              dir_dn_i,
  input  logic [1:0]        rep_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic [AW-1:0]     pc_i,
  input  logic [AW-1:0]     src_i,
  input  logic [AW-1:0]     dst_i,
  input  logic [AW-1:0]     cnt_i,
  input  logic [PORT_W-1:0] port_i,
  input  logic              zf_i,
  output logic              req_valid_o,
  input  logic              req_ready_i,
  output logic              req_write_o,
  output logic              req_port_o,
  output logic [AW-1:0]     req_addr_o,
  output logic [2:0]        req_bytes_o,
  output logic              busy_o,
  output logic              done_o,
  output logic [AW-1:0]     src_o,
  output logic [AW-1:0]     dst_o,
  output logic [AW-1:0]     cnt_o,
  output logic [AW-1:0]     pc_o
);
  localparam int NLANE    = 3;
  localparam int SRC_LANE = 0;
  localparam int DST_LANE = 1;
  localparam int CNT_LANE = 2;

  // Reset: asserted asynchronously, released on the clock
  logic [1:0] rsync_q;
  logic       rst_i_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_i_n = rsync_q[1];

  // Instruction context captured at start
  str_op_e          op_q;
  rep_e             rep_q;
  logic [1:0]       esz_q;
  logic             a32_q, dn_q;
  logic [LEN_W-1:0] len_q;
  logic [PORT_W-1:0] port_q;
  logic [AW-1:0]    pc_q, pc_d;
  logic             done_q;

  seq_st_e st;
  logic    load_en, upd_en, fin;
  op_dec_t dec;
  phase_t  ph;
  logic [2:0] nbytes;
  logic    cnt_zero;
  logic [AW-1:0] lane_q   [NLANE];
  logic [AW-1:0] lane_ini [NLANE];
  logic [NLANE-1:0] lane_mv;
  logic [AW-1:0] sel_ptr;

  always_comb begin
    dec       = decode_op(op_q);
    nbytes    = (esz_q == 2'd0) ? 3'd1 : (esz_q == 2'd1) ? 3'd2 : 3'd4;
    cnt_zero  = a32_q ? (lane_q[CNT_LANE] == '0) : (lane_q[CNT_LANE][NW-1:0] == '0);
    lane_ini[SRC_LANE] = src_i;
    lane_ini[DST_LANE] = dst_i;
    lane_ini[CNT_LANE] = cnt_i;
    lane_mv   = {rep_q != REP_NONE, dec.dst_mv, dec.src_mv};
    ph        = (st == S_PH1) ? dec.p1 : dec.p0;
    sel_ptr   = ph.use_dst ? lane_q[DST_LANE] : lane_q[SRC_LANE];
    pc_d      = pc_q + {{(AW-LEN_W){1'b0}}, len_q};
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      op_q <= OP_MOVE; rep_q <= REP_NONE; esz_q <= '0; a32_q <= 1'b0;
      dn_q <= 1'b0; len_q <= '0; port_q <= '0;
    end else if (load_en) begin
      op_q <= str_op_e'(op_i); rep_q <= rep_e'(rep_i); esz_q <= esize_i;
      a32_q <= addr32_i; dn_q <= dir_dn_i; len_q <= len_i; port_q <= port_i;
    end
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n)     pc_q <= '0;
    else if (load_en) pc_q <= pc_i;
    else if (fin)     pc_q <= pc_d;
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) done_q <= 1'b0;
    else          done_q <= fin;
  end

  // One index/count lane per register; the count lane always steps down by one
  for (genvar g = 0; g < NLANE; g++) begin : g_lane
    localparam bit IS_CNT = (g == CNT_LANE);
    logic [AW-1:0] q, d, nxt;
    logic          en;

    str_idx_step #(.AW(AW), .NW(NW)) u_step (
      .val_i  (q),
      .step_i (IS_CNT ? 3'd1 : nbytes),
      .dn_i   (IS_CNT ? 1'b1 : dn_q),
      .wide_i (a32_q),
      .nxt_o  (nxt)
    );

    always_comb begin
      en = load_en || (upd_en && lane_mv[g]);
      d  = load_en ? lane_ini[g] : nxt;
    end

    always_ff @(posedge clk or negedge rst_i_n) begin
      if (!rst_i_n) q <= '0;
      else if (en)  q <= d;
    end

    assign lane_q[g] = q;
  end

  str_seq_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_i_n),
    .start_i    (start_i),
    .rep_i      (rep_q),
    .zf_term_i  (dec.zf_term),
    .two_i      (dec.two),
    .cnt_zero_i (cnt_zero),
    .ready_i    (req_ready_i),
    .zf_i       (zf_i),
    .st_o       (st),
    .load_o     (load_en),
    .upd_o      (upd_en),
    .fin_o      (fin)
  );

  assign req_valid_o = (st == S_PH0) || (st == S_PH1);
  assign req_write_o = ph.wr;
  assign req_port_o  = ph.port;
  assign req_addr_o  = ph.port ? {{(AW-PORT_W){1'b0}}, port_q}
                     : (a32_q ? sel_ptr : {{(AW-NW){1'b0}}, sel_ptr[NW-1:0]});
  assign req_bytes_o = nbytes;
  assign busy_o      = (st != S_IDLE);
  assign done_o      = done_q;
  assign src_o       = lane_q[SRC_LANE];
  assign dst_o       = lane_q[DST_LANE];
  assign cnt_o       = lane_q[CNT_LANE];
  assign pc_o        = pc_q;

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_i_n)
    (req_valid_o && !req_ready_i) |=> (req_valid_o && $stable(req_addr_o)
      && $stable(req_write_o) && $stable(req_port_o))); // R10
  AST_NO_MOVE_WHILE_PENDING: assert property (@(posedge clk) disable iff (!rst_i_n)
    (req_valid_o && !req_ready_i) |=> ($stable(src_o) && $stable(dst_o) && $stable(cnt_o))); // R10
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_i_n)
    done_o |=> !done_o); // R9
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_i_n)
    done_o |-> !busy_o); // R9
  AST_NOREP_COUNT_KEPT: assert property (@(posedge clk) disable iff (!rst_i_n)
    (busy_o && (rep_q == REP_NONE)) |=> $stable(cnt_o)); // R8
endmodule

// File: tb/str_seq_top_tb_top.sv
`timescale 1ns/1ps
module str_seq_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n, start_i, addr32_i, dir_dn_i, zf_i, req_ready_i;
  logic [2:0]  op_i;
  logic [1:0]  esize_i, rep_i;
  logic [3:0]  len_i;
  logic [31:0] pc_i, src_i, dst_i, cnt_i;
  logic [15:0] port_i;
  logic        req_valid_o, req_write_o, req_port_o, busy_o, done_o;
  logic [31:0] req_addr_o, src_o, dst_o, cnt_o, pc_o;
  logic [2:0]  req_bytes_o;

  always #2.5 clk = ~clk;

  str_seq_top dut_i (.*);

  typedef struct packed {
    logic wr; logic port; logic [31:0] addr; logic [2:0] nb; logic last; logic zf;
  } item_t;

  item_t expq[$];
  int    n_cmp = 0;
  int    n_bad = 0;
  int    tick  = 0;
  bit    prev_pend = 1'b0;
  logic [31:0] prev_addr = '0;
  string cur_tag = "R1";
  bit    finished = 1'b0;

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // Monitor: drives ready and zero flag, pops and compares the scoreboard
  initial begin
    req_ready_i = 1'b0;
    zf_i = 1'b0;
    forever begin
      @(negedge clk);
      tick++;
      req_ready_i = (tick % 4) != 3;
      #0.5;
      if (prev_pend) begin
        chk("R10", "pending valid held", {31'd0, req_valid_o}, 32'd1);
        chk("R10", "pending addr held", req_addr_o, prev_addr);
      end
      prev_pend = req_valid_o && !req_ready_i;
      prev_addr = req_addr_o;
      if (req_valid_o && req_ready_i) begin
        if (expq.size() == 0) begin
          chk(cur_tag, "unexpected request", 32'd1, 32'd0);
        end else begin
          item_t e;
          e = expq.pop_front();
          chk(cur_tag, "req write", {31'd0, req_write_o}, {31'd0, e.wr});
          chk(cur_tag, "req port", {31'd0, req_port_o}, {31'd0, e.port});
          chk(cur_tag, "req addr", req_addr_o, e.addr);
          chk(cur_tag, "req bytes", {29'd0, req_bytes_o}, {29'd0, e.nb});
          if (e.last) zf_i = e.zf;
        end
      end
    end
  end

  function automatic logic [31:0] stp(logic [31:0] v, int b, bit dn, bit a32);
    logic [15:0] lo;
    if (a32) return dn ? v - b : v + b;
    lo = dn ? v[15:0] - 16'(b) : v[15:0] + 16'(b);
    return {v[31:16], lo};
  endfunction

  function automatic logic [31:0] ma(logic [31:0] v, bit a32);
    return a32 ? v : {16'h0, v[15:0]};
  endfunction

  function automatic bit czero(logic [31:0] v, bit a32);
    return a32 ? (v == 0) : (v[15:0] == 0);
  endfunction

  task automatic push(bit wr, bit port, logic [31:0] a, int nb, bit last, bit zf);
    item_t e;
    e.wr = wr; e.port = port; e.addr = a; e.nb = 3'(nb); e.last = last; e.zf = zf;
    expq.push_back(e);
  endtask

  task automatic run_case(string tag, int op, int esz, bit a32, bit dn, int rep,
                          logic [31:0] s0, logic [31:0] d0, logic [31:0] c0,
                          logic [15:0] zfv, logic [15:0] prt, int len, logic [31:0] pc0);
    logic [31:0] s, d, c, pa;
    int  nb, k;
    bit  go, z, term, seen;
    nb = (esz == 0) ? 1 : (esz == 1) ? 2 : 4;
    s = s0; d = d0; c = c0; k = 0;
    pa = {16'h0, prt};
    term = (op == 1) || (op == 4);
    go = !((rep != 0) && czero(c, a32));
    while (go) begin
      z = zfv[k];
      case (op)
        0: begin push(0, 0, ma(s, a32), nb, 0, z); push(1, 0, ma(d, a32), nb, 1, z); end
        1: begin push(0, 0, ma(s, a32), nb, 0, z); push(0, 0, ma(d, a32), nb, 1, z); end
        2: push(1, 0, ma(d, a32), nb, 1, z);
        3: push(0, 0, ma(s, a32), nb, 1, z);
        4: push(0, 0, ma(d, a32), nb, 1, z);
        5: begin push(0, 1, pa, nb, 0, z); push(1, 0, ma(d, a32), nb, 1, z); end
        default: begin push(0, 0, ma(s, a32), nb, 0, z); push(1, 1, pa, nb, 1, z); end
      endcase
      if (op == 0 || op == 1 || op == 3 || op == 6) s = stp(s, nb, dn, a32);
      if (op == 0 || op == 1 || op == 2 || op == 4 || op == 5) d = stp(d, nb, dn, a32);
      if (rep != 0) c = stp(c, 1, 1'b1, a32);
      k++;
      if (rep == 0) go = 0;
      else if (term && rep == 1 && !z) go = 0;
      else if (term && rep == 2 && z) go = 0;
      else if (czero(c, a32)) go = 0;
    end
    cur_tag = tag;
    @(negedge clk);
    op_i = 3'(op); esize_i = 2'(esz); addr32_i = a32; dir_dn_i = dn; rep_i = 2'(rep);
    len_i = 4'(len); pc_i = pc0; src_i = s0; dst_i = d0; cnt_i = c0; port_i = prt;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    seen = 1'b0;
    for (int i = 0; i < 3000; i++) begin
      #1;
      if (done_o) begin seen = 1'b1; break; end
      @(negedge clk);
    end
    chk(tag, "done reached (R9)", {31'd0, seen}, 32'd1);
    chk(tag, "busy low at done (R9)", {31'd0, busy_o}, 32'd0);
    chk(tag, "final src (R3)", src_o, s);
    chk(tag, "final dst (R3)", dst_o, d);
    chk(tag, "final count (R6)", cnt_o, c);
    chk("R9", "pc after done", pc_o, pc0 + len);
    chk(tag, "requests left over", expq.size(), 0);
    expq.delete();
    @(negedge clk);
    #1;
    chk("R9", "done single cycle", {31'd0, done_o}, 32'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; start_i = 1'b0; op_i = '0; esize_i = '0; addr32_i = 1'b1;
    dir_dn_i = 1'b0; rep_i = '0; len_i = '0; pc_i = '0; src_i = '0; dst_i = '0;
    cnt_i = '0; port_i = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    chk("R1", "busy after reset", {31'd0, busy_o}, 32'd0);
    chk("R1", "done after reset", {31'd0, done_o}, 32'd0);
    chk("R1", "req valid after reset", {31'd0, req_valid_o}, 32'd0);

    // R2 R3 R6: move, count repeat, 4-byte elements upward
    run_case("R2", 0, 2, 1, 0, 3, 32'h1000, 32'h2000, 32'd3, 16'h0, 16'h0, 2, 32'h100);
    // R7: compare while equal stops on third element (zf 1,1,0)
    run_case("R7", 1, 0, 1, 0, 1, 32'h3000, 32'h4000, 32'd5, 16'b011, 16'h0, 3, 32'h200);
    // R7 R3: scan while not equal, downward, stops on second (zf 0,1)
    run_case("R7", 4, 1, 1, 1, 2, 32'h0, 32'h5010, 32'd4, 16'b10, 16'h0, 2, 32'h300);
    // R5: zero count under repeat
    run_case("R5", 2, 2, 1, 0, 1, 32'h10, 32'h6000, 32'd0, 16'h0, 16'h0, 1, 32'h400);
    // R8: no repeat prefix, count kept
    run_case("R8", 3, 1, 1, 1, 0, 32'h7002, 32'h0, 32'd7, 16'h0, 16'h0, 1, 32'h500);
    // R8: no repeat with zero count still performs one element
    run_case("R8", 1, 0, 1, 0, 0, 32'h8000, 32'h9000, 32'd0, 16'h0, 16'h0, 2, 32'h600);
    // R4: port input, 16-bit addressing, destination wraps upward
    run_case("R4", 5, 1, 0, 0, 3, 32'h0, 32'h1234FFFE, 32'h00010002, 16'h0, 16'h0060, 2, 32'h700);
    // R4: port output, 16-bit addressing, source wraps downward
    run_case("R4", 6, 0, 0, 1, 3, 32'hABCD0001, 32'h0, 32'd2, 16'h0, 16'h0080, 1, 32'h800);
    // R7: move ignores zero flag under while-equal
    run_case("R7", 0, 0, 1, 0, 1, 32'hA000, 32'hB000, 32'd2, 16'h0, 16'h0, 2, 32'h900);
    // R7: compare under count-only repeat ignores zero flag
    run_case("R7", 1, 2, 1, 1, 3, 32'hC100, 32'hD100, 32'd3, 16'h0, 16'h0, 3, 32'hA00);
    // R6: compare while not equal runs to exhaustion with zf always 0
    run_case("R6", 1, 1, 1, 0, 2, 32'hE000, 32'hF000, 32'd3, 16'h0, 16'h0, 2, 32'hB00);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule